// File: doc/BRIEF.md
# Bit-Transposing Shift-Register Output Expander

This block widens a small number of chip pins into many parallel output lines by driving a daisy chain of external 8-bit serial-in, parallel-out shift registers. Each register has its own output latch. Only three pins are used: a serial data line, a shift clock and a latch clock. The chain is `LINES` bits long, which means `LINES/8` cascaded stages. Output line `i` is the parallel output at chain position `i`.

A client hands over `LINES` bytes at once through a valid/ready handshake, one byte for each output line. The block does not send each byte as a unit. It transposes the group: latched update `k` carries bit `k` of every byte, one bit per line. A group therefore produces eight latched updates, bit 0 first. Each update is shifted in completely before the latch is pulsed, so every line changes at the same instant. A one-cycle done strobe marks the end of each latch pulse.

Pin timing is set by `HALF_CYC`, the number of system clock cycles in each half-period of the shift clock. With a 50 MHz system clock, the default of 2 gives an 80 ns shift period. That is well within the 25 ns minimum period of the external devices.

Top module: `sre_expander`

## Requirements
- R1: After reset, `sh_clk`, `lat_clk`, `ser_data` and `done` are low and `in_ready` is high.
- R2: Byte `i` of a group is `in_data[8*i+7:8*i]`. In latched update `k` (k = 0..7, in that order), output line `i` equals bit `k` of byte `i`.
- R3: Each latched update is preceded by exactly `LINES` rising edges of `sh_clk`. The bit for line `LINES-1` is shifted first and the bit for line 0 last.
- R4: `lat_clk` is never high while `sh_clk` is high, and it rises only after all `LINES` bits of the word have been shifted.
- R5: `ser_data` settles at least `HALF_CYC` clock cycles before each rising `sh_clk` edge. It stays stable for as long as `sh_clk` is high.
- R6: Each high phase of `sh_clk` lasts exactly `HALF_CYC` clock cycles.
- R7: Each `lat_clk` pulse lasts exactly `2*HALF_CYC` clock cycles. The next rising `sh_clk` edge comes at least `HALF_CYC` cycles after `lat_clk` falls.
- R8: `done` is a single-cycle pulse that occurs in the cycle where `lat_clk` falls. There is exactly one such pulse per latched update, so eight per group.
- R9: A group is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low from then until the group ends, and `in_valid` or `in_data` presented while `in_ready` is low has no effect on any update.
- R10: `in_ready` is high again by the time the eighth `done` pulse of a group appears, so groups can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte group is offered |
| in_ready | output | 1 | Block is idle and will take a group |
| in_data | input | 8*LINES | One byte per output line, byte i in bits 8i+7..8i |
| done | output | 1 | One-cycle strobe at the end of each latch pulse |
| ser_data | output | 1 | Serial data to the first stage of the chain |
| sh_clk | output | 1 | Shift clock of the chain |
| lat_clk | output | 1 | Output-latch clock of the chain |

## Verification
The bench models the chain behaviourally and compares the lines after each latch with the transposed column. A design that sends whole bytes, or that picks bit positions in the wrong order, shows up as a wrong column. A design that shifts LSB-first reverses the lines. An off-by-one in the bit counter leaves the chain misaligned by one position and is caught through the edge count. The bench also injects a second group while the block is busy, so a design that captures data without qualifying it by `in_ready` corrupts the later columns. Shift edges that arrive too soon after a data change or after the latch falls, and a latch that overlaps the shift clock, are measured in time at the pins.

// File: rtl/sre_pkg.sv
package sre_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LATCH = 2'd3
  } sre_state_e;

  // Number of bit positions in a byte: one latched update per position.
  localparam int unsigned COLS = 8;

  // Flat index of bit k of byte i inside the parallel input vector.
  function automatic int unsigned flat_pos(int unsigned byte_i, int unsigned bit_k);
    return byte_i * COLS + bit_k;
  endfunction

  // True when a phase timer has reached the final cycle of a phase of len cycles.
  function automatic logic phase_last(int unsigned tmr, int unsigned len);
    return tmr == (len - 1);
  endfunction

endpackage

// File: rtl/sre_transpose.sv
module sre_transpose #(
  parameter int unsigned LINES = 16
) (
  input  logic [8*LINES-1:0] grp_data,
  input  logic [2:0]         col_idx,
  output logic [LINES-1:0]   col_word
);
  // Column col_idx of the byte matrix: bit col_idx of every byte.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [7:0] byte_v;
    assign byte_v      = grp_data[8*i +: 8];
    assign col_word[i] = byte_v[col_idx];
  end
endmodule

// File: rtl/sre_sequencer.sv
module sre_sequencer
  import sre_pkg::*;
#(
  parameter int unsigned LINES    = 16,
  parameter int unsigned HALF_CYC = 2,
  localparam int unsigned BW      = $clog2(LINES),
  localparam int unsigned TW      = $clog2(2*HALF_CYC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          accept,
  output sre_state_e    state,
  output logic [BW-1:0] bit_idx,
  output logic [2:0]    col_idx
);
  logic [TW-1:0] tmr;
  logic          lo_end, hi_end, lat_end;

  assign accept  = in_valid && (state == ST_IDLE);
  assign lo_end  = (state == ST_LOW)   && phase_last(int'(tmr), HALF_CYC);
  assign hi_end  = (state == ST_HIGH)  && phase_last(int'(tmr), HALF_CYC);
  assign lat_end = (state == ST_LATCH) && phase_last(int'(tmr), 2*HALF_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      bit_idx <= '0;
      col_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tmr <= '0;
          if (accept) begin
            state   <= ST_LOW;
            bit_idx <= BW'(LINES-1);
            col_idx <= '0;
          end
        end
        ST_LOW: begin
          if (lo_end) begin
            tmr   <= '0;
            state <= ST_HIGH;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_HIGH: begin
          if (hi_end) begin
            tmr <= '0;
            if (bit_idx == '0) begin
              state <= ST_LATCH;
            end else begin
              bit_idx <= bit_idx - 1'b1;
              state   <= ST_LOW;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_LATCH: begin
          if (lat_end) begin
            tmr <= '0;
            if (col_idx == 3'd7) begin
              state <= ST_IDLE;
            end else begin
              col_idx <= col_idx + 1'b1;
              bit_idx <= BW'(LINES-1);
              state   <= ST_LOW;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sre_pin_stage.sv
module sre_pin_stage
  import sre_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sre_state_e state,
  input  logic       cur_bit,
  output logic       ser_data,
  output logic       sh_clk,
  output logic       lat_clk,
  output logic       done
);
  // Every pin is delayed by the same single register, so the relative
  // timing of state phases is kept exactly at the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_data <= 1'b0;
      sh_clk   <= 1'b0;
      lat_clk  <= 1'b0;
      done     <= 1'b0;
    end else begin
      ser_data <= ((state == ST_LOW) || (state == ST_HIGH)) ? cur_bit : 1'b0;
      sh_clk   <= (state == ST_HIGH);
      lat_clk  <= (state == ST_LATCH);
      done     <= lat_clk && (state != ST_LATCH);
    end
  end
endmodule

// File: rtl/sre_expander.sv
module sre_expander
  import sre_pkg::*;
#(
  parameter int unsigned LINES    = 16,
  parameter int unsigned HALF_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*LINES-1:0] in_data,
  output logic               done,
  output logic               ser_data,
  output logic               sh_clk,
  output logic               lat_clk
);
  localparam int unsigned BW = $clog2(LINES);

  sre_state_e        state;
  logic              accept;
  logic [BW-1:0]     bit_idx;
  logic [2:0]        col_idx;
  logic [8*LINES-1:0] grp_q;
  logic [LINES-1:0]  col_word;
  logic              cur_bit;

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grp_q <= '0;
    else if (accept) grp_q <= in_data;
  end

  sre_sequencer #(.LINES(LINES), .HALF_CYC(HALF_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .accept  (accept),
    .state   (state),
    .bit_idx (bit_idx),
    .col_idx (col_idx)
  );

  sre_transpose #(.LINES(LINES)) u_tp (
    .grp_data(grp_q),
    .col_idx (col_idx),
    .col_word(col_word)
  );

  assign cur_bit = col_word[bit_idx];

  sre_pin_stage u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .cur_bit (cur_bit),
    .ser_data(ser_data),
    .sh_clk  (sh_clk),
    .lat_clk (lat_clk),
    .done    (done)
  );
endmodule

// File: rtl/sre_expander_chk.sv
module sre_expander_chk #(
  parameter int unsigned LINES    = 16,
  parameter int unsigned HALF_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic done,
  input logic ser_data,
  input logic sh_clk,
  input logic lat_clk
);
  logic       sh_d, lat_d;
  logic [5:0] rise_cnt;
  logic [7:0] hi_len, lat_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_d <= 1'b0; lat_d <= 1'b0; rise_cnt <= '0; hi_len <= '0; lat_len <= '0;
    end else begin
      sh_d    <= sh_clk;
      lat_d   <= lat_clk;
      hi_len  <= sh_clk  ? hi_len + 1'b1  : 8'd0;
      lat_len <= lat_clk ? lat_len + 1'b1 : 8'd0;
      if (done)                rise_cnt <= '0;
      else if (sh_clk && !sh_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_full_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_clk && !lat_d) |-> (rise_cnt == 6'(LINES)));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_clk |-> !sh_clk);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_clk && sh_d) |-> $stable(ser_data));

  assert_high_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_clk && sh_d) |-> (hi_len == 8'(HALF_CYC)));

  assert_latch_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_clk && lat_d) |-> (lat_len == 8'(2*HALF_CYC)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!lat_clk && lat_d));

  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind sre_expander sre_expander_chk #(.LINES(LINES), .HALF_CYC(HALF_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .done    (done),
  .ser_data(ser_data),
  .sh_clk  (sh_clk),
  .lat_clk (lat_clk)
);

// File: tb/sre_expander_tb.sv
`timescale 1ns/1ps
module sre_expander_tb_top;
  localparam int unsigned L  = 16;
  localparam int unsigned H  = 2;
  localparam time         TP = 20;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [8*L-1:0] in_data = '0;
  logic in_ready, done, ser_data, sh_clk, lat_clk;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sre_expander #(.LINES(L), .HALF_CYC(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done(done), .ser_data(ser_data), .sh_clk(sh_clk), .lat_clk(lat_clk)
  );

  // Behavioural model of the external register chain and pin-timing monitors.
  logic [L-1:0] chain = '0, lines_m = '0;
  int  bit_cnt = 0, bits_at = 0;
  int  su_bad = 0, ovl_bad = 0, gap_bad = 0, lat_w = 0;
  time sd_t = 0, lr_t = 0, lf_t = 0;
  bit  lat_seen = 1'b0;

  always @(ser_data) sd_t = $time;

  always @(posedge sh_clk) begin
    chain = {chain[L-2:0], ser_data};
    bit_cnt++;
    if (lat_clk) ovl_bad++;
    if ($time - sd_t < H*TP) su_bad++;
    if (lat_seen && ($time - lf_t < H*TP)) gap_bad++;
  end

  always @(posedge lat_clk) begin
    if (sh_clk) ovl_bad++;
    lines_m = chain;
    bits_at = bit_cnt;
    bit_cnt = 0;
    lr_t    = $time;
  end

  always @(negedge lat_clk) begin
    lat_w    = int'(($time - lr_t) / TP);
    lf_t     = $time;
    lat_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] column(input logic [8*L-1:0] g, input int k);
    logic [L-1:0] c;
    for (int i = 0; i < L; i++) c[i] = g[i*8 + k];
    return c;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!sh_clk && !lat_clk && !ser_data && !done, "R1 pins low in reset",
          {sh_clk, lat_clk, ser_data, done}, 0);
    check(in_ready, "R1 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !sh_clk && !lat_clk, "R1 idle after reset", {in_ready, sh_clk, lat_clk}, 3'b100);
  endtask

  // Send one group and check all eight updates; optionally inject junk while busy.
  task automatic t_group(input logic [8*L-1:0] g, input bit junk, input string tag);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = g;
    @(negedge clk);
    in_valid = 1'b0; in_data = ~g;
    check(!in_ready, "R9 busy after accept", in_ready, 0);
    for (int k = 0; k < 8; k++) begin
      su_bad = 0; ovl_bad = 0; gap_bad = 0;
      if (junk && k == 2) begin
        check(!in_ready, "R9 not ready mid-group", in_ready, 0);
        in_valid = 1'b1; in_data = {L{8'h5A}} ^ g;
        repeat (6) @(negedge clk);
        in_valid = 1'b0;
      end
      while (!done) @(negedge clk);
      check(!lat_clk, "R8 done at latch fall", lat_clk, 0);
      check(lines_m == column(g, k), {"R2 column ", tag}, lines_m, column(g, k));
      check(bits_at == L, "R3 shifts per update", bits_at, L);
      check(su_bad == 0 && ovl_bad == 0, "R4/R5 setup and overlap", su_bad + ovl_bad, 0);
      check(lat_w == 2*H, "R7 latch width", lat_w, 2*H);
      check(gap_bad == 0, "R7 gap after latch", gap_bad, 0);
      if (k == 7) check(in_ready, "R10 ready at last done", in_ready, 1);
      @(negedge clk);
      check(!done, "R8 done single cycle", done, 0);
    end
  endtask

  // R6: measure one shift-clock high phase at the pins.
  task automatic t_clock_shape();
    logic [8*L-1:0] g;
    int hi;
    for (int i = 0; i < L; i++) g[i*8 +: 8] = 8'(i * 37 + 11);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = g;
    @(negedge clk);
    in_valid = 1'b0;
    while (!sh_clk) @(negedge clk);
    hi = 0;
    while (sh_clk) begin hi++; @(negedge clk); end
    check(hi == H, "R6 shift high width", hi, H);
    for (int k = 0; k < 8; k++) begin
      while (!done) @(negedge clk);
      check(lines_m == column(g, k), "R2 column after shape test", lines_m, column(g, k));
      @(negedge clk);
    end
  endtask

  initial begin
    logic [8*L-1:0] g;
    logic [31:0] s;
    t_reset();
    g = '0;
    for (int i = 0; i < L; i++) g[i*8 +: 8] = 8'h01 << (i % 8);
    t_group(g, 1'b0, "one-hot bytes");
    t_group({L{8'hFF}}, 1'b0, "all ones");
    t_group({L{8'hA5}}, 1'b1, "A5 with junk while busy");
    g = '0; g[8*(L-1) +: 8] = 8'h80;
    t_group(g, 1'b0, "MSB line only");
    s = 32'h1234_5678;
    for (int i = 0; i < L; i++) begin s = s * 32'd1664525 + 32'd1013904223; g[i*8 +: 8] = s[31:24]; end
    t_group(g, 1'b0, "pseudo-random back-to-back A");
    t_group(~g, 1'b0, "pseudo-random back-to-back B");
    t_clock_shape();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule